// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block gives a processor two 32-bit event counters for profiling. A 64-bit register port reaches both the control word and the counters. Each counter watches one of sixteen event lines, chosen by its own 4-bit selector in the control word. It counts only while the processor's current privilege mode is one of the modes enabled in that word.

Software presets a counter to 0x80000000 minus the wanted sample period. Bit 31 of the counter then sets after exactly that many events. While the interrupt enable is on and either counter has bit 31 set, the block drives a level interrupt. Software clears the condition by rewriting both counters with new presets in one 64-bit write.

Top module: `evc_pair`

## Requirements
- R1: Reset (synchronous, active high) clears the control word and both counters, and holds `irq` low.
- R2: A write with `reg_sel`=0 stores `reg_wdata[12:0]` as the control word. A control read returns that word with bits 63:13 as zero.
- R3: A write with `reg_sel`=1 loads both counters in the same cycle: counter 1 from bits 31:0 and counter 2 from bits 63:32. A read with `reg_sel`=1 returns the counters in the same layout.
- R4: On each clock, a counter goes up by one when its selected event line is high and the current mode is enabled. Counter 1's event index is control bits 8:5 and counter 2's is control bits 12:9. `mode` is encoded 0 = exception, 1 = kernel, 2 = supervisor, 3 = user, and mode m is enabled by control bit m (bits 3:0).
- R5: While the control bit for the current mode is clear, neither counter changes.
- R6: Event lines other than a counter's selected one have no effect on that counter.
- R7: While the control word is zero, neither counter changes, whatever the events or the mode.
- R8: `irq` is high exactly when control bit 4 (interrupt enable) is set and bit 31 of either counter is set.
- R9: A counter preset to 0x80000000 − P shows bit 31 clear after P−1 counted events and set after P.
- R10: A counter write in the same cycle as a counted event loads the written value, and the event is lost.
- R11: A counter at 0xFFFFFFFF wraps to 0 on its next counted event, and its bit 31 clears.
- R12: Reads change no state: repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Current privilege mode |
| events | input | 16 | Event lines |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the counter word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
A counter-word write and a counted event can land on the same clock edge. The bench provokes this by holding counter 1's event line high in an enabled mode while it writes a new preset. Immediately after that edge the counter must read back the preset exactly, not the preset plus one. One cycle later it must read the preset plus one, which shows counting resumes from the loaded value.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int CNT_W   = 32;
    localparam int NUM_CNT = 2;
    localparam int EV_N    = 16;
    localparam int SEL_W   = $clog2(EV_N);
    localparam int MODE_N  = 4;
    localparam int MODE_W  = $clog2(MODE_N);
    localparam int WORD_W  = NUM_CNT * CNT_W;
    localparam int CTRL_W  = MODE_N + 1 + NUM_CNT * SEL_W;

    typedef enum logic [MODE_W-1:0] {
        PM_EXC  = 2'd0,
        PM_KERN = 2'd1,
        PM_SUP  = 2'd2,
        PM_USER = 2'd3
    } pmode_e;

    typedef struct packed {
        logic [NUM_CNT-1:0][SEL_W-1:0] ev_sel;
        logic                          int_en;
        logic [MODE_N-1:0]             mode_en;
    } ctrl_t;

    function automatic logic top_bit(input logic [CNT_W-1:0] v);
        return v[CNT_W-1];
    endfunction
endpackage

// File: rtl/evc_mode_qual.sv
module evc_mode_qual
    import evc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [MODE_N-1:0] mode_en,
    output logic              allow
);
    pmode_e cur;
    always_comb begin
        cur   = pmode_e'(mode);
        allow = mode_en[cur];
    end
endmodule

// File: rtl/evc_slice.sv
module evc_slice #(
    parameter int CNT_W = 32,
    parameter int EV_N  = 16,
    localparam int SEL_W = $clog2(EV_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             allow,
    input  logic [EV_N-1:0]  events,
    input  logic [SEL_W-1:0] sel,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic hit;
    logic [CNT_W-1:0] cnt_q;

    assign hit = allow & events[sel];

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (hit)
            cnt_q <= cnt_q + ONE;
    end

    assign cnt = cnt_q;

    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        ld |=> cnt_q == $past(ld_val));
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && hit) |=> cnt_q == $past(cnt_q) + ONE);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld && !hit) |=> $stable(cnt_q));
    a_r11_wrap: assert property (@(posedge clk) disable iff (rst)
        (!ld && hit && cnt_q == FULL) |=> (cnt_q == '0 && !cnt_q[CNT_W-1]));
endmodule

// File: rtl/evc_pair.sv
module evc_pair
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [EV_N-1:0]   events,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              allow;
    logic              cnt_ld;
    logic [WORD_W-1:0] cnt_word;
    logic [NUM_CNT-1:0] ovf;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (reg_we && !reg_sel)
            ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    evc_mode_qual u_qual (
        .mode    (mode),
        .mode_en (ctrl_q.mode_en),
        .allow   (allow)
    );

    assign cnt_ld = reg_we & reg_sel;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [CNT_W-1:0] c;
        evc_slice #(.CNT_W(CNT_W), .EV_N(EV_N)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .allow  (allow),
            .events (events),
            .sel    (ctrl_q.ev_sel[i]),
            .ld     (cnt_ld),
            .ld_val (reg_wdata[i*CNT_W +: CNT_W]),
            .cnt    (c)
        );
        assign cnt_word[i*CNT_W +: CNT_W] = c;
        assign ovf[i] = top_bit(c);
    end

    assign reg_rdata = reg_sel ? cnt_word : {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
    assign irq = ctrl_q.int_en & (|ovf);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && cnt_word == '0));
    a_r7_stopped: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q == '0 && !cnt_ld) |=> $stable(cnt_word));
    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(ctrl_q));
endmodule

// File: tb/evc_pair_test.sv
module evc_pair_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [15:0] events = '0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    evc_pair uut (
        .clk(clk), .rst(rst), .mode(mode), .events(events),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [63:0] mk_ctrl(input logic [3:0] men, input logic ie,
                                            input logic [3:0] e1, input logic [3:0] e2);
        return 64'({e2, e1, ie, men});
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [63:0] d);
        reg_sel = s; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [63:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] ev, input int n);
        events = ev;
        cyc(n);
        events = '0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(1'b0, v); chk("R1 ctrl", v, 64'd0);
        rd(1'b1, v); chk("R1 counters", v, 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
    endtask

    task automatic t_ctrl_rw();
        logic [63:0] v;
        wr(1'b0, 64'hFFFF_0000_0000_FFFF);
        rd(1'b0, v); chk("R2 ctrl readback", v, 64'h1FFF);
        wr(1'b0, 64'd0);
    endtask

    task automatic t_cnt_rw();
        logic [63:0] v;
        wr(1'b1, 64'h1234_5678_9ABC_DEF0);
        rd(1'b1, v); chk("R3 word load", v, 64'h1234_5678_9ABC_DEF0);
        cyc(3);
        rd(1'b1, v); chk("R12 repeated read", v, 64'h1234_5678_9ABC_DEF0);
        rd(1'b0, v); chk("R12 ctrl unchanged", v, 64'd0);
    endtask

    task automatic t_count();
        logic [63:0] v;
        wr(1'b1, 64'd0);
        wr(1'b0, mk_ctrl(4'b1000, 1'b0, 4'd3, 4'd7));
        mode = 2'd3;
        pulse(16'h0008, 5);
        rd(1'b1, v); chk("R4 counter1 only", v, {32'd0, 32'd5});
        pulse(16'h0088, 4);
        rd(1'b1, v); chk("R4 both counters", v, {32'd4, 32'd9});
        pulse(16'hFF77, 6);
        rd(1'b1, v); chk("R6 other lines ignored", v, {32'd4, 32'd9});
        mode = 2'd1;
        pulse(16'h0088, 4);
        rd(1'b1, v); chk("R5 kernel not enabled", v, {32'd4, 32'd9});
        for (int m = 0; m < 4; m++) begin
            wr(1'b1, 64'd0);
            wr(1'b0, mk_ctrl(4'(1 << m), 1'b0, 4'd3, 4'd7));
            mode = 2'(m);
            pulse(16'h0088, 2);
            mode = 2'((m + 1) % 4);
            pulse(16'h0088, 3);
            rd(1'b1, v); chk("R4 R5 per mode", v, {32'd2, 32'd2});
        end
    endtask

    task automatic t_stop();
        logic [63:0] v;
        wr(1'b1, 64'h0000_0010_0000_0020);
        wr(1'b0, 64'd0);
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            pulse(16'hFFFF, 2);
        end
        rd(1'b1, v); chk("R7 zero control stops", v, 64'h0000_0010_0000_0020);
    endtask

    task automatic t_overflow();
        logic [63:0] v;
        mode = 2'd3;
        wr(1'b1, {32'd0, 32'h8000_0000 - 32'd6});
        wr(1'b0, mk_ctrl(4'b1000, 1'b1, 4'd2, 4'd9));
        pulse(16'h0004, 5);
        rd(1'b1, v); chk("R9 one short", 64'(v[31]), 64'd0);
        chk("R8 irq low before overflow", 64'(irq), 64'd0);
        pulse(16'h0004, 1);
        rd(1'b1, v); chk("R9 flag after period", v, {32'd0, 32'h8000_0000});
        chk("R8 irq high", 64'(irq), 64'd1);
        wr(1'b0, mk_ctrl(4'b1000, 1'b0, 4'd2, 4'd9));
        chk("R8 irq masked", 64'(irq), 64'd0);
        wr(1'b0, mk_ctrl(4'b1000, 1'b1, 4'd2, 4'd9));
        chk("R8 irq unmasked", 64'(irq), 64'd1);
        wr(1'b1, {32'h8000_0000 - 32'd3, 32'h8000_0000 - 32'd3});
        chk("R8 irq cleared by rewrite", 64'(irq), 64'd0);
        pulse(16'h0200, 3);
        chk("R8 irq from counter2", 64'(irq), 64'd1);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        mode = 2'd3;
        wr(1'b0, mk_ctrl(4'b1000, 1'b0, 4'd1, 4'd1));
        wr(1'b1, 64'h0000_0000_0000_0050);
        events = 16'h0002;
        cyc(2);
        wr(1'b1, 64'h0000_0005_0000_0100);
        rd(1'b1, v); chk("R10 write wins", v, 64'h0000_0005_0000_0100);
        cyc(1);
        rd(1'b1, v); chk("R10 count resumes", v, 64'h0000_0006_0000_0101);
        events = '0;
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        mode = 2'd2;
        wr(1'b0, mk_ctrl(4'b0100, 1'b1, 4'd0, 4'd4));
        wr(1'b1, {32'hFFFF_FFFF, 32'd7});
        chk("R8 irq at max", 64'(irq), 64'd1);
        pulse(16'h0010, 1);
        rd(1'b1, v); chk("R11 wrap to zero", v, {32'd0, 32'd7});
        chk("R11 flag clears", 64'(irq), 64'd0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_ctrl_rw();
        t_cnt_rw();
        t_count();
        t_stop();
        t_overflow();
        t_collide();
        t_wrap();
        wr(1'b0, 64'h1FFF);
        wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule